// File: doc/BRIEF.md
# Serial Unit Status Flag Register

This block holds the five status and interrupt flags of a synchronous serial unit: receive data full, transmit data empty, transmit end, conflict error and overrun error. The receive and transmit engines report their events as single-cycle pulses. The block turns those pulses into sticky flags, each with its own level interrupt request. Software reads the flags as one 8-bit value.

Software clears a flag by reading the register while the flag is 1 and then writing 0 to that bit. Writing 1 never sets a flag, and a 0 written without that earlier read does nothing.

An overrun stops all further transfers through a halt output. The block also tells the receive path whether a received byte may be stored. After an overrun, the stored byte is the last good one and later bytes are dropped. When the unit works as a slave that only receives, in its native mode, overrun detection is turned off.

Top module: `serial_flag_reg`

## Requirements
- R1: After reset, the register reads 0x04: transmit data empty is 1 and all other bits are 0. The halt output is 0.
- R2: Register bit positions are: bit 6 overrun, bit 3 transmit end, bit 2 transmit data empty, bit 1 receive data full, bit 0 conflict. Bits 7, 5 and 4 always read 0, and writes to them have no effect.
- R3: When a byte completes (rxDone) while receive data full is 0 and overrun is 0, rxLoad is high in that cycle and receive data full is set at the next edge. A rxDataRead pulse clears receive data full.
- R4: When a byte completes while receive data full is 1, overrun is set and rxLoad stays low. Receive data full stays 1, so the earlier byte is kept.
- R5: In slave receive-only mode (masterSel 0, txEn 0, rxEn 1, modeSel 0), a byte completing while receive data full is 1 does not set overrun.
- R6: haltXfer equals the overrun flag. While overrun is 1, a completed byte neither asserts rxLoad nor sets receive data full.
- R7: A write of 0 clears a flag only if the last register read since the previous write returned that flag as 1. Every write consumes all such read marks.
- R8: Writing 1 to any bit never sets a flag.
- R9: When a flag's set event and a clear (software or hardware) arrive in the same cycle, the flag ends up 1.
- R10: txBufWrite clears transmit data empty and transmit end. txToShift sets transmit data empty. frameEnd sets transmit end only when transmit data empty is already 1.
- R11: A conflict pulse sets the conflict flag.
- R12: Each flag drives its own interrupt output, which is 1 exactly while that flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxDone | input | 1 | Pulse: one byte finished receiving |
| rxDataRead | input | 1 | Pulse: receive data register was read |
| txBufWrite | input | 1 | Pulse: transmit buffer written |
| txToShift | input | 1 | Pulse: transmit buffer moved to shifter |
| frameEnd | input | 1 | Pulse: transmit frame ended |
| conflict | input | 1 | Pulse: conflict detected |
| masterSel | input | 1 | 1 = master, 0 = slave |
| txEn | input | 1 | Transmit enable |
| rxEn | input | 1 | Receive enable |
| modeSel | input | 1 | 0 = native mode |
| regRd | input | 1 | CPU read strobe |
| regWr | input | 1 | CPU write strobe |
| wrData | input | 8 | CPU write data |
| rdData | output | 8 | Register value |
| rxLoad | output | 1 | Store the received byte this cycle |
| haltXfer | output | 1 | Stop both shifters |
| irqConflict | output | 1 | Conflict interrupt request |
| irqRxFull | output | 1 | Receive full interrupt request |
| irqTxEmpty | output | 1 | Transmit empty interrupt request |
| irqTxEnd | output | 1 | Transmit end interrupt request |
| irqOverrun | output | 1 | Overrun interrupt request |

## Verification
The hardest states to reach are the ones where several flag rules meet in one cycle. One is a software clear that was armed by an earlier read and lands on the same edge as a hardware set. Another is a second byte arriving in slave receive-only mode. The bench reaches them with a chosen order of single-cycle pulses: first a read to arm the clear, then on the next cycle a write of 0 together with the set pulse. It also changes the four mode inputs between bursts of received bytes, so the same back-to-back receive pattern is seen with overrun detection both on and off.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  localparam int REG_W = 8;
  localparam int NFLAG = 5;

  localparam int F_CONF  = 0;
  localparam int F_RXF   = 1;
  localparam int F_TXE   = 2;
  localparam int F_TXEND = 3;
  localparam int F_OVR   = 4;

  localparam logic [NFLAG-1:0] FLAG_RST = 5'b00100;

  // Register bit that carries each internal flag index
  function automatic int flagBit(input int idx);
    case (idx)
      F_CONF:  return 0;
      F_RXF:   return 1;
      F_TXE:   return 2;
      F_TXEND: return 3;
      default: return 6;
    endcase
  endfunction

  typedef struct packed {
    logic [NFLAG-1:0] setFlag;
    logic [NFLAG-1:0] hwClr;
    logic [NFLAG-1:0] cpuClr;
  } flagStrobes_t;
endpackage

// File: rtl/ssf_ctrl.sv
module ssf_ctrl
  import ssf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxDone,
  input  logic             rxDataRead,
  input  logic             txBufWrite,
  input  logic             txToShift,
  input  logic             frameEnd,
  input  logic             conflict,
  input  logic             masterSel,
  input  logic             txEn,
  input  logic             rxEn,
  input  logic             modeSel,
  input  logic             regRd,
  input  logic             regWr,
  input  logic [REG_W-1:0] wrData,
  input  logic [NFLAG-1:0] flags,
  output flagStrobes_t     strobes,
  output logic             rxLoad
);
  logic [NFLAG-1:0] armQ;
  logic slaveRxOnly, blocked, rxAccept, ovrHit;

  // A read marks every flag it saw as 1; a write uses up the marks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       armQ <= '0;
    else if (regRd)  armQ <= flags;
    else if (regWr)  armQ <= '0;
  end

  assign slaveRxOnly = !masterSel && !txEn && rxEn && !modeSel;
  assign blocked     = flags[F_OVR];
  assign rxAccept    = rxDone && !blocked && !flags[F_RXF];
  assign ovrHit      = rxDone && !blocked && flags[F_RXF] && !slaveRxOnly;
  assign rxLoad      = rxAccept;

  always_comb begin
    strobes = '0;
    strobes.setFlag[F_RXF]   = rxAccept;
    strobes.setFlag[F_OVR]   = ovrHit;
    strobes.setFlag[F_TXE]   = txToShift;
    strobes.setFlag[F_TXEND] = frameEnd && flags[F_TXE];
    strobes.setFlag[F_CONF]  = conflict;
    strobes.hwClr[F_RXF]     = rxDataRead;
    strobes.hwClr[F_TXE]     = txBufWrite;
    strobes.hwClr[F_TXEND]   = txBufWrite;
    for (int i = 0; i < NFLAG; i++)
      strobes.cpuClr[i] = regWr && armQ[i] && !wrData[flagBit(i)];
  end
endmodule

// File: rtl/ssf_datapath.sv
module ssf_datapath
  import ssf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  flagStrobes_t     strobes,
  output logic [NFLAG-1:0] flags,
  output logic [REG_W-1:0] rdData
);
  logic [NFLAG-1:0] flagQ;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                     flagQ[i] <= FLAG_RST[i];
      else if (strobes.setFlag[i])                   flagQ[i] <= 1'b1;
      else if (strobes.hwClr[i] || strobes.cpuClr[i]) flagQ[i] <= 1'b0;
    end
  end

  assign flags = flagQ;

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NFLAG; i++)
      rdData[flagBit(i)] = flagQ[i];
  end
endmodule

// File: rtl/serial_flag_reg.sv
module serial_flag_reg
  import ssf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxDone,
  input  logic             rxDataRead,
  input  logic             txBufWrite,
  input  logic             txToShift,
  input  logic             frameEnd,
  input  logic             conflict,
  input  logic             masterSel,
  input  logic             txEn,
  input  logic             rxEn,
  input  logic             modeSel,
  input  logic             regRd,
  input  logic             regWr,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             rxLoad,
  output logic             haltXfer,
  output logic             irqConflict,
  output logic             irqRxFull,
  output logic             irqTxEmpty,
  output logic             irqTxEnd,
  output logic             irqOverrun
);
  flagStrobes_t     strobes;
  logic [NFLAG-1:0] flags;

  ssf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxDone(rxDone), .rxDataRead(rxDataRead),
    .txBufWrite(txBufWrite), .txToShift(txToShift), .frameEnd(frameEnd),
    .conflict(conflict), .masterSel(masterSel), .txEn(txEn), .rxEn(rxEn),
    .modeSel(modeSel), .regRd(regRd), .regWr(regWr), .wrData(wrData),
    .flags(flags), .strobes(strobes), .rxLoad(rxLoad)
  );

  ssf_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .flags(flags), .rdData(rdData)
  );

  assign haltXfer    = flags[F_OVR];
  assign irqConflict = flags[F_CONF];
  assign irqRxFull   = flags[F_RXF];
  assign irqTxEmpty  = flags[F_TXE];
  assign irqTxEnd    = flags[F_TXEND];
  assign irqOverrun  = flags[F_OVR];
endmodule

// File: rtl/serial_flag_reg_chk.sv
module serial_flag_reg_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rxDone,
  input logic       regWr,
  input logic       masterSel,
  input logic       txEn,
  input logic       rxEn,
  input logic       modeSel,
  input logic [7:0] rdData,
  input logic       rxLoad,
  input logic       haltXfer,
  input logic       irqRxFull,
  input logic       irqOverrun
);
  logic slaveMode;
  assign slaveMode = !masterSel && !txEn && rxEn && !modeSel;

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[7] == 1'b0 && rdData[5:4] == 2'b00);
  // R4
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && rdData[1] && !slaveMode |=> rdData[6]);
  // R5
  slave_no_ovr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[6] && slaveMode |=> !rdData[6]);
  // R6
  halt_tracks_ovr_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltXfer == rdData[6]);
  // R8
  ovr_only_by_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[6] && !rxDone |=> !rdData[6]);
  // R7
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[6] && !regWr |=> rdData[6]);
  // R3
  rx_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxLoad |-> !rdData[1] && !rdData[6]);
  // R12
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqRxFull == rdData[1] && irqOverrun == rdData[6]);
endmodule

bind serial_flag_reg serial_flag_reg_chk u_chk (
  .clk(clk), .rstN(rstN), .rxDone(rxDone), .regWr(regWr),
  .masterSel(masterSel), .txEn(txEn), .rxEn(rxEn), .modeSel(modeSel),
  .rdData(rdData), .rxLoad(rxLoad), .haltXfer(haltXfer),
  .irqRxFull(irqRxFull), .irqOverrun(irqOverrun)
);

// File: tb/serial_flag_reg_bench.sv
`timescale 1ns/1ps
module serial_flag_reg_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxDone = 0, rxDataRead = 0, txBufWrite = 0, txToShift = 0, frameEnd = 0, conflict = 0;
  logic masterSel = 1, txEn = 1, rxEn = 1, modeSel = 0;
  logic regRd = 0, regWr = 0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic rxLoad, haltXfer, irqConflict, irqRxFull, irqTxEmpty, irqTxEnd, irqOverrun;

  int checkCount = 0;
  int failCount = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] expVal;
    string      tag;
  } expItem_t;
  expItem_t sb[$];

  always #5 clk = ~clk;

  serial_flag_reg u_serial_flag_reg (
    .clk(clk), .rstN(rstN), .rxDone(rxDone), .rxDataRead(rxDataRead),
    .txBufWrite(txBufWrite), .txToShift(txToShift), .frameEnd(frameEnd),
    .conflict(conflict), .masterSel(masterSel), .txEn(txEn), .rxEn(rxEn),
    .modeSel(modeSel), .regRd(regRd), .regWr(regWr), .wrData(wrData),
    .rdData(rdData), .rxLoad(rxLoad), .haltXfer(haltXfer),
    .irqConflict(irqConflict), .irqRxFull(irqRxFull), .irqTxEmpty(irqTxEmpty),
    .irqTxEnd(irqTxEnd), .irqOverrun(irqOverrun)
  );

  // Monitor: compares the register, halt (R6) and interrupt levels (R12)
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      expItem_t it;
      logic [13:0] act, exp;
      it = sb.pop_front();
      act = {rdData, haltXfer, irqOverrun, irqTxEnd, irqTxEmpty, irqRxFull, irqConflict};
      exp = {it.expVal, it.expVal[6], it.expVal[6], it.expVal[3], it.expVal[2],
             it.expVal[1], it.expVal[0]};
      checkCount++;
      if (act !== exp) begin
        failCount++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, exp);
      end
    end
  end

  task automatic tick(input logic [7:0] expVal, input string tag);
    @(posedge clk);
    #1;
    sb.push_back('{expVal, tag});
    @(negedge clk);
    rxDone = 0; rxDataRead = 0; txBufWrite = 0; txToShift = 0;
    frameEnd = 0; conflict = 0; regRd = 0; regWr = 0; wrData = '0;
  endtask

  task automatic checkLoad(input logic expLoad, input string tag);
    #1;
    checkCount++;
    if (rxLoad !== expLoad) begin
      failCount++;
      $display("FAIL %s: rxLoad actual %b expected %b", tag, rxLoad, expLoad);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tick(8'h04, "R1 reset value");
    regWr = 1; wrData = 8'hFF;
    tick(8'h04, "R2 R8 write ones without read");
    rxDone = 1; checkLoad(1'b1, "R3 load on first byte");
    tick(8'h06, "R3 rx full set");
    rxDone = 1; checkLoad(1'b0, "R4 no load on overrun");
    tick(8'h46, "R4 overrun set, halt");
    rxDataRead = 1;
    tick(8'h44, "R3 rx data read clears full");
    rxDone = 1; checkLoad(1'b0, "R6 no load while halted");
    tick(8'h44, "R6 byte dropped while halted");
    regWr = 1; wrData = 8'h00;
    tick(8'h44, "R7 unarmed write zero");
    regRd = 1;
    tick(8'h44, "R7 read arms");
    regWr = 1; wrData = 8'hBF;
    tick(8'h04, "R7 armed clear of overrun");
    regWr = 1; wrData = 8'h00;
    tick(8'h04, "R7 marks consumed by write");
    masterSel = 0; txEn = 0; rxEn = 1; modeSel = 0;
    rxDone = 1;
    tick(8'h06, "R5 slave first byte");
    rxDone = 1; checkLoad(1'b0, "R5 slave second byte not stored");
    tick(8'h06, "R5 no overrun in slave rx only");
    rxDataRead = 1;
    tick(8'h04, "R5 slave read");
    masterSel = 1; txEn = 1;
    txBufWrite = 1;
    tick(8'h00, "R10 buffer write clears empty");
    frameEnd = 1;
    tick(8'h00, "R10 frame end ignored while not empty");
    txToShift = 1;
    tick(8'h04, "R10 move to shifter sets empty");
    frameEnd = 1;
    tick(8'h0C, "R10 frame end sets tx end");
    txBufWrite = 1;
    tick(8'h00, "R10 buffer write clears both");
    txToShift = 1;
    tick(8'h04, "R10 empty again");
    conflict = 1;
    tick(8'h05, "R11 conflict set");
    regRd = 1;
    tick(8'h05, "R9 read arms");
    regWr = 1; wrData = 8'h00; conflict = 1;
    tick(8'h01, "R9 set beats armed clear");
    regRd = 1;
    tick(8'h01, "R7 read arms conflict");
    regWr = 1; wrData = 8'h00;
    tick(8'h00, "R7 conflict cleared");
    rxDone = 1; rxDataRead = 1;
    tick(8'h02, "R9 set beats hardware clear");
    rxDataRead = 1;
    tick(8'h00, "R3 final clear");
    @(negedge clk);
    @(negedge clk);
    finishRun();
  end
endmodule